// File: doc/BRIEF.md
# Per-Load Stride Prefetch Predictor

This block watches the stream of committed loads and learns, for each load instruction, whether its successive addresses move by a constant step. A direct-mapped table, indexed by low bits of the load's program counter, holds one record per tracked load. Each record keeps a tag, the most recent address the load used, the step last learned, and a two-bit confidence state. Every load that arrives with its valid strobe is checked against its record. The record is then updated, and once the confidence state says the step is reliable, the block requests the line one step ahead of the current access.

The prefetch request is registered and appears one clock after the load that caused it, as an address with a valid flag. The cache or memory side that consumes the request is outside this block. Table size and all widths are parameters. By default the table has 16 entries and takes 32-bit PCs and addresses, with PC bit 2 as the lowest index bit.

Top module: `spf_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pf_valid` is 0 and `pf_addr` is 0, and every table entry is empty.
- R2: A cycle with `ld_valid` low produces no prefetch in the next cycle and leaves the table unchanged, whatever `ld_pc` and `ld_addr` carry.
- R3: The entry is chosen by `ld_pc[PC_LSB+IDX_W-1:PC_LSB]`, and all remaining PC bits form the tag. A load that finds an empty entry or a different tag allocates the entry with state init, stride 0 and the load's address, and it issues no prefetch.
- R4: A load that hits its entry is correct when `ld_addr` equals the stored previous address plus the stored stride, both taken modulo 2^ADDR_W, so negative steps work.
- R5: A prefetch is issued one cycle after a hitting load exactly when the entry's new state is steady and its new stride is non-zero. `pf_addr` is then `ld_addr` plus the stride. While `pf_valid` is low, `pf_addr` is 0.
- R6: On a correct load, init and transient move to steady, steady stays steady, and no-prediction moves to transient. The stride is kept.
- R7: On an incorrect load in steady, the entry falls back to init and keeps its stride.
- R8: On an incorrect load, init moves to transient, transient moves to no-prediction, and no-prediction stays there. In each of these cases the stride is replaced by `ld_addr` minus the previous address.
- R9: A load repeating the same address reaches steady with stride 0 and never issues a prefetch.
- R10: Every load that hits an entry stores its address as the entry's previous address, whether or not it was correct.
- R11: A load whose PC maps to an occupied entry with a different tag evicts it. The evicted load, when it returns, starts again from init.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_pc | input | PC_W | Program counter of the load |
| ld_addr | input | ADDR_W | Data address of the load |
| pf_valid | output | 1 | Prefetch request valid, one cycle after its load |
| pf_addr | output | ADDR_W | Address to prefetch, 0 when idle |

## Verification
On every cycle, the bound checker enforces four rules. A prefetch only follows a valid load that hit its entry. A prefetch never targets the address just loaded, which guards the non-zero stride rule. The request address stays 0 while idle, and reset keeps the output quiet. The state walk itself can only be shown by the bench's directed sequences. These cover the learning of a stride, a steady entry dropping to init with its stride kept, a climb out of no-prediction, zero and negative steps, eviction on a tag conflict, and a load with its strobe low. Each sequence has its expected prefetch worked out by hand.

// File: rtl/spf_pkg.sv
package spf_pkg;

    // Confidence of one table entry
    typedef enum logic [1:0] {
        CONF_INIT   = 2'd0,
        CONF_STEADY = 2'd1,
        CONF_TRANS  = 2'd2,
        CONF_NOPRED = 2'd3
    } conf_e;

endpackage

// File: rtl/spf_decode.sv
module spf_decode #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int IDX_W  = 4,
    localparam int TAG_W = PC_W - IDX_W
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);

    assign idx = pc[PC_LSB+IDX_W-1:PC_LSB];

    // Tag holds every PC bit not used for the index
    generate
        if (PC_LSB == 0) begin : g_no_low
            assign tag = pc[PC_W-1:IDX_W];
        end else begin : g_with_low
            assign tag = {pc[PC_W-1:PC_LSB+IDX_W], pc[PC_LSB-1:0]};
        end
    endgenerate

endmodule

// File: rtl/spf_predict.sv
module spf_predict
    import spf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              hit,
    input  conf_e             state_q,
    input  logic [ADDR_W-1:0] stride_q,
    input  logic [ADDR_W-1:0] prev_q,
    input  logic [ADDR_W-1:0] addr,
    output conf_e             state_d,
    output logic [ADDR_W-1:0] stride_d,
    output logic              issue,
    output logic [ADDR_W-1:0] target
);

    logic [ADDR_W-1:0] expect_addr;
    logic [ADDR_W-1:0] delta;
    logic              correct;

    always_comb begin
        expect_addr = prev_q + stride_q;
        delta       = addr - prev_q;
        correct     = (addr == expect_addr);

        state_d  = CONF_INIT;
        stride_d = '0;

        if (hit) begin
            stride_d = stride_q;
            unique case (state_q)
                CONF_INIT: begin
                    if (correct) begin
                        state_d = CONF_STEADY;
                    end else begin
                        state_d  = CONF_TRANS;
                        stride_d = delta;
                    end
                end
                CONF_STEADY: begin
                    // a broken run keeps the learned step
                    state_d = correct ? CONF_STEADY : CONF_INIT;
                end
                CONF_TRANS: begin
                    if (correct) begin
                        state_d = CONF_STEADY;
                    end else begin
                        state_d  = CONF_NOPRED;
                        stride_d = delta;
                    end
                end
                CONF_NOPRED: begin
                    if (correct) begin
                        state_d = CONF_TRANS;
                    end else begin
                        state_d  = CONF_NOPRED;
                        stride_d = delta;
                    end
                end
                default: begin
                    state_d = CONF_INIT;
                end
            endcase
        end

        issue  = hit && (state_d == CONF_STEADY) && (stride_d != '0);
        target = addr + stride_d;
    end

endmodule

// File: rtl/spf_table.sv
module spf_table
    import spf_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 28,
    parameter int ADDR_W = 32,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_vld,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_prev,
    output logic [ADDR_W-1:0] rd_stride,
    output conf_e             rd_state,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_prev,
    input  logic [ADDR_W-1:0] wr_stride,
    input  conf_e             wr_state
);

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] prev;
        logic [ADDR_W-1:0] stride;
        conf_e             state;
    } ent_t;

    ent_t ent_q [DEPTH];
    ent_t ent_d [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            always_comb begin
                ent_d[g] = ent_q[g];
                if (wr_en && (wr_idx == IDX_W'(g))) begin
                    ent_d[g].vld    = 1'b1;
                    ent_d[g].tag    = wr_tag;
                    ent_d[g].prev   = wr_prev;
                    ent_d[g].stride = wr_stride;
                    ent_d[g].state  = wr_state;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ent_q[g] <= '{vld: 1'b0, tag: '0, prev: '0,
                                  stride: '0, state: CONF_INIT};
                end else begin
                    ent_q[g] <= ent_d[g];
                end
            end
        end
    endgenerate

    assign rd_vld    = ent_q[rd_idx].vld;
    assign rd_tag    = ent_q[rd_idx].tag;
    assign rd_prev   = ent_q[rd_idx].prev;
    assign rd_stride = ent_q[rd_idx].stride;
    assign rd_state  = ent_q[rd_idx].state;

endmodule

// File: rtl/spf_top.sv
module spf_top
    import spf_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int PC_LSB = 2,
    localparam int TAG_W = PC_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [PC_W-1:0]   ld_pc,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } out_t;

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              rd_vld;
    logic [TAG_W-1:0]  rd_tag;
    logic [ADDR_W-1:0] rd_prev;
    logic [ADDR_W-1:0] rd_stride;
    conf_e             rd_state;
    logic              lookup_hit;
    conf_e             nx_state;
    logic [ADDR_W-1:0] nx_stride;
    logic              nx_issue;
    logic [ADDR_W-1:0] nx_target;
    out_t              out_d;
    out_t              out_q;

    spf_decode #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W)) u_dec (
        .pc  (ld_pc),
        .idx (lk_idx),
        .tag (lk_tag)
    );

    spf_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_tab (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_idx),
        .rd_vld    (rd_vld),
        .rd_tag    (rd_tag),
        .rd_prev   (rd_prev),
        .rd_stride (rd_stride),
        .rd_state  (rd_state),
        .wr_en     (ld_valid),
        .wr_idx    (lk_idx),
        .wr_tag    (lk_tag),
        .wr_prev   (ld_addr),
        .wr_stride (nx_stride),
        .wr_state  (nx_state)
    );

    assign lookup_hit = ld_valid && rd_vld && (rd_tag == lk_tag);

    spf_predict #(.ADDR_W(ADDR_W)) u_pred (
        .hit      (lookup_hit),
        .state_q  (rd_state),
        .stride_q (rd_stride),
        .prev_q   (rd_prev),
        .addr     (ld_addr),
        .state_d  (nx_state),
        .stride_d (nx_stride),
        .issue    (nx_issue),
        .target   (nx_target)
    );

    always_comb begin
        out_d.vld  = nx_issue;
        out_d.addr = nx_issue ? nx_target : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pf_valid = out_q.vld;
    assign pf_addr  = out_q.addr;

endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_valid,
    input logic [ADDR_W-1:0] ld_addr,
    input logic              hit,
    input logic              pf_valid,
    input logic [ADDR_W-1:0] pf_addr
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !pf_valid);

    a_r2_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> $past(ld_valid));

    a_r3_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> $past(hit));

    a_r9_step_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr != $past(ld_addr)));

    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !pf_valid |-> (pf_addr == '0));

endmodule

bind spf_top spf_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_addr  (ld_addr),
    .hit      (lookup_hit),
    .pf_valid (pf_valid),
    .pf_addr  (pf_addr)
);

// File: tb/sim_spf_top.sv
module sim_spf_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_pc = '0;
    logic [31:0] ld_addr = '0;
    logic        pf_valid;
    logic [31:0] pf_addr;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    localparam logic [31:0] PC_A = 32'h400; // index 0
    localparam logic [31:0] PC_B = 32'h404; // index 1
    localparam logic [31:0] PC_C = 32'h408; // index 2
    localparam logic [31:0] PC_E = 32'h40C; // index 3
    localparam logic [31:0] PC_D = 32'h800; // index 0, other tag

    always #10 clk = ~clk;

    spf_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_pc    (ld_pc),
        .ld_addr  (ld_addr),
        .pf_valid (pf_valid),
        .pf_addr  (pf_addr)
    );

    task automatic check(string req, logic ev, logic [31:0] ea);
        checks++;
        if (pf_valid !== ev || pf_addr !== ea) begin
            errors++;
            $display("FAIL %s: got valid=%0b addr=%h, expected valid=%0b addr=%h",
                     req, pf_valid, pf_addr, ev, ea);
        end
    endtask

    // drive one load at a falling edge, sample the registered result one cycle later
    task automatic load(logic [31:0] pc, logic [31:0] a, logic ev,
                        logic [31:0] ea, string req);
        ld_pc    = pc;
        ld_addr  = a;
        ld_valid = 1'b1;
        @(negedge clk);
        ld_valid = 1'b0;
        check(req, ev, ea);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 1'b0, 32'h0);
    endtask

    task automatic t_learn();
        load(PC_A, 32'h1000, 1'b0, 32'h0,    "R3 allocate");
        load(PC_A, 32'h1008, 1'b0, 32'h0,    "R8 init->transient");
        load(PC_A, 32'h1010, 1'b1, 32'h1018, "R6 transient->steady R5");
        load(PC_A, 32'h1018, 1'b1, 32'h1020, "R6 steady holds R4");
    endtask

    task automatic t_break_steady();
        load(PC_A, 32'h1100, 1'b0, 32'h0,    "R7 steady->init");
        load(PC_A, 32'h1108, 1'b1, 32'h1110, "R7 stride kept R10");
    endtask

    task automatic t_nopred();
        load(PC_B, 32'h2000, 1'b0, 32'h0,    "R3 allocate B");
        load(PC_B, 32'h2004, 1'b0, 32'h0,    "R8 init->transient B");
        load(PC_B, 32'h2010, 1'b0, 32'h0,    "R8 transient->nopred");
        load(PC_B, 32'h2020, 1'b0, 32'h0,    "R8 nopred holds");
        load(PC_B, 32'h2030, 1'b0, 32'h0,    "R6 nopred->transient");
        load(PC_B, 32'h2040, 1'b1, 32'h2050, "R6 transient->steady B");
    endtask

    task automatic t_idle();
        ld_pc    = PC_B;
        ld_addr  = 32'h9999;
        ld_valid = 1'b0;
        @(negedge clk);
        check("R2 no load", 1'b0, 32'h0);
        load(PC_B, 32'h2050, 1'b1, 32'h2060, "R2 table untouched");
    endtask

    task automatic t_zero();
        load(PC_C, 32'h3000, 1'b0, 32'h0, "R9 allocate C");
        load(PC_C, 32'h3000, 1'b0, 32'h0, "R9 steady zero stride");
        load(PC_C, 32'h3000, 1'b0, 32'h0, "R9 still quiet");
    endtask

    task automatic t_negative();
        load(PC_E, 32'h5000, 1'b0, 32'h0,    "R3 allocate E");
        load(PC_E, 32'h4FF0, 1'b0, 32'h0,    "R8 negative step");
        load(PC_E, 32'h4FE0, 1'b1, 32'h4FD0, "R4 negative wrap R5");
    endtask

    task automatic t_conflict();
        load(PC_D, 32'h7000, 1'b0, 32'h0,    "R11 evict A");
        load(PC_A, 32'h1110, 1'b0, 32'h0,    "R11 A misses");
        load(PC_A, 32'h1118, 1'b0, 32'h0,    "R11 A restarts init");
        load(PC_A, 32'h1120, 1'b1, 32'h1128, "R11 A relearns");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_learn();
        t_break_steady();
        t_nopred();
        t_idle();
        t_zero();
        t_negative();
        t_conflict();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule